// File: doc/BRIEF.md
# Serial BCD Display Shift-Out Driver

This block sends a four-digit time value (hours and minutes, one BCD digit per display decoder) to a chain of external serial-in parallel-out registers. It uses only two outputs: a serial data line and a shift clock. The external registers have no output latch, so partial data shows on their outputs while a frame is moving. For that reason a frame is shifted as one gapless burst of 16 clock periods, and the burst is short compared with how fast a display or an eye responds.

The board may connect the register outputs to the decoder inputs in any order. A writable remap table therefore chooses which logical bit of the time word is sent in each shift slot. A transfer starts with a one-cycle start pulse. A busy flag stays high while the frame is moving, and a one-cycle done pulse marks the end. After every frame the data line returns to low, so no input of an unpowered neighbour is held high. While main power is reported absent, both lines are forced low, no transfer starts, and any running transfer is dropped.

Top module: `bcd_shift_driver`

## Requirements
- R1: After reset, ser_data_o, ser_clk_o, busy_o and done_o are all 0.
- R2: A start_i pulse seen while idle with mains_ok_i high sets busy_o in the next cycle. It then produces exactly 16 rising edges of ser_clk_o, spaced 2*HALF_DIV cycles apart. Each clock level lasts HALF_DIV cycles. done_o rises 32*HALF_DIV cycles after the cycle in which busy_o first reads 1.
- R3: Shift slot k (k = 0 is sent first) carries bit map[k] of digits_i. digits_i holds the hours tens digit in bits [15:12], hours units in [11:8], minutes tens in [7:4] and minutes units in [3:0]. After reset, map[k] = 15 - k, so a chain that shifts toward its high end ends up holding digits_i unchanged.
- R4: ser_data_o changes only while ser_clk_o is low. It is stable for the whole high phase, and the receiver samples it on the rising edge.
- R5: When a frame completes, ser_data_o and ser_clk_o are 0. done_o is high for exactly one cycle, and busy_o is already 0 in that cycle.
- R6: A start_i pulse that arrives while busy_o is high is ignored. The running frame finishes unchanged and no second frame follows.
- R7: While mains_ok_i is low, ser_data_o and ser_clk_o are 0 in the same cycle and start_i is ignored. A frame in progress is abandoned: busy_o drops at the next edge and no done_o pulse is issued.
- R8: When map_we_i is high at a clock edge, map_data_i is written to map entry map_addr_i. The new entry applies to frames started afterwards. A frame already in progress keeps the mapping it latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to send digits_i |
| digits_i | input | 16 | Four BCD digits, hours tens in the top nibble |
| mains_ok_i | input | 1 | High while main power is present |
| map_we_i | input | 1 | Write enable for the remap table |
| map_addr_i | input | 4 | Shift slot whose entry is written |
| map_data_i | input | 4 | Logical bit index to send in that slot |
| ser_data_o | output | 1 | Serial data to the register chain |
| ser_clk_o | output | 1 | Shift clock to the register chain |
| busy_o | output | 1 | High while a frame is being shifted |
| done_o | output | 1 | One-cycle pulse when a frame completes |

## Verification
A corrupted slot counter or frame register shows up as a wrong number of rising shift edges, or as a chain image that differs from the remapped digits. A bench that models the register chain sees either fault within one frame of 32*HALF_DIV cycles. A stuck or wrong state also breaks the relation between busy_o, done_o and the line levels, and the checker flags that in the very cycle it occurs: a high line while idle, data moving during a high clock phase, or done_o without 16 edges. A mapping error appears only for digit values whose bits differ across the swapped positions, so the bench uses both a reversed map and a table write made in the middle of a frame.

// File: rtl/bcd_shift_pkg.sv
package bcd_shift_pkg;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_LOW  = 2'd1,
        SH_HIGH = 2'd2
    } sh_state_e;

endpackage

// File: rtl/bcd_remap_table.sv
module bcd_remap_table #(
    parameter int NBITS = 16,
    parameter int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] addr_i,
    input  logic [IDX_W-1:0] data_i,
    input  logic [NBITS-1:0] word_i,
    output logic [NBITS-1:0] frame_o
);

    logic [IDX_W-1:0] map_d [NBITS];
    logic [IDX_W-1:0] map_q [NBITS];

    always_comb begin
        for (int k = 0; k < NBITS; k++) begin
            map_d[k] = map_q[k];
        end
        if (we_i) begin
            map_d[addr_i] = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NBITS; k++) begin
                map_q[k] <= IDX_W'(NBITS - 1 - k);
            end
        end else begin
            for (int k = 0; k < NBITS; k++) begin
                map_q[k] <= map_d[k];
            end
        end
    end

    // slot k of the outgoing frame picks logical bit map[k]
    for (genvar k = 0; k < NBITS; k++) begin : g_slot
        assign frame_o[k] = word_i[map_q[k]];
    end

endmodule

// File: rtl/bcd_tick_gen.sv
module bcd_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/bcd_shift_fsm.sv
module bcd_shift_fsm
    import bcd_shift_pkg::*;
#(
    parameter int NBITS = 16,
    parameter int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mains_ok_i,
    input  logic             tick_i,
    input  logic [NBITS-1:0] frame_i,
    output logic             tick_clr_o,
    output logic             sdat_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NBITS - 1);

    typedef struct packed {
        sh_state_e        st;
        logic [IDX_W-1:0] idx;
        logic [NBITS-1:0] frame;
        logic             sdat;
        logic             sclk;
        logic             busy;
        logic             done;
    } fsm_t;

    localparam fsm_t FSM_RESET = '{
        st:    SH_IDLE,
        idx:   '0,
        frame: '0,
        sdat:  1'b0,
        sclk:  1'b0,
        busy:  1'b0,
        done:  1'b0
    };

    fsm_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        tick_clr_o = 1'b0;
        if (!mains_ok_i) begin
            // no power downstream: drop everything, keep lines low
            r_d = FSM_RESET;
        end else begin
            unique case (r_q.st)
                SH_IDLE: begin
                    if (start_i) begin
                        r_d.st     = SH_LOW;
                        r_d.idx    = '0;
                        r_d.sdat   = frame_i[0];
                        r_d.frame  = frame_i >> 1;
                        r_d.sclk   = 1'b0;
                        r_d.busy   = 1'b1;
                        tick_clr_o = 1'b1;
                    end
                end
                SH_LOW: begin
                    if (tick_i) begin
                        r_d.sclk = 1'b1;
                        r_d.st   = SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    if (tick_i) begin
                        r_d.sclk = 1'b0;
                        if (r_q.idx == LAST_SLOT) begin
                            r_d.st   = SH_IDLE;
                            r_d.sdat = 1'b0;
                            r_d.busy = 1'b0;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.st    = SH_LOW;
                            r_d.idx   = r_q.idx + 1'b1;
                            r_d.sdat  = r_q.frame[0];
                            r_d.frame = r_q.frame >> 1;
                        end
                    end
                end
                default: r_d = FSM_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= FSM_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdat_o = r_q.sdat;
    assign sclk_o = r_q.sclk;
    assign busy_o = r_q.busy;
    assign done_o = r_q.done;

endmodule

// File: rtl/bcd_shift_driver.sv
module bcd_shift_driver #(
    parameter int DIGITS   = 4,
    parameter int DIG_W    = 4,
    parameter int HALF_DIV = 4,
    localparam int NBITS   = DIGITS * DIG_W,
    localparam int IDX_W   = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NBITS-1:0] digits_i,
    input  logic             mains_ok_i,
    input  logic             map_we_i,
    input  logic [IDX_W-1:0] map_addr_i,
    input  logic [IDX_W-1:0] map_data_i,
    output logic             ser_data_o,
    output logic             ser_clk_o,
    output logic             busy_o,
    output logic             done_o
);

    logic [NBITS-1:0] frame;
    logic             tick;
    logic             tick_clr;
    logic             sdat;
    logic             sclk;

    bcd_remap_table #(
        .NBITS (NBITS),
        .IDX_W (IDX_W)
    ) remap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (map_we_i),
        .addr_i  (map_addr_i),
        .data_i  (map_data_i),
        .word_i  (digits_i),
        .frame_o (frame)
    );

    bcd_tick_gen #(
        .HALF_DIV (HALF_DIV)
    ) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    bcd_shift_fsm #(
        .NBITS (NBITS),
        .IDX_W (IDX_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mains_ok_i (mains_ok_i),
        .tick_i     (tick),
        .frame_i    (frame),
        .tick_clr_o (tick_clr),
        .sdat_o     (sdat),
        .sclk_o     (sclk),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    // lines go low in the same cycle that power is reported missing
    assign ser_data_o = sdat & mains_ok_i;
    assign ser_clk_o  = sclk & mains_ok_i;

endmodule

// File: rtl/bcd_shift_driver_chk.sv
module bcd_shift_driver_chk #(
    parameter int NBITS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic mains_ok_i,
    input logic ser_data_o,
    input logic ser_clk_o,
    input logic busy_o,
    input logic done_o
);

    logic       clk_prev_q;
    logic [7:0] edge_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b0;
            edge_cnt_q <= '0;
        end else begin
            clk_prev_q <= ser_clk_o;
            if (start_i && !busy_o && mains_ok_i) begin
                edge_cnt_q <= '0;
            end else if (ser_clk_o && !clk_prev_q) begin
                edge_cnt_q <= edge_cnt_q + 1'b1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy_o && !done_o && !ser_clk_o && !ser_data_o); // R1

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && mains_ok_i) |=> busy_o); // R2

    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> edge_cnt_q <= 8'(NBITS)); // R2

    AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> edge_cnt_q == 8'(NBITS)); // R2

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_o && clk_prev_q) |-> $stable(ser_data_o)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ser_clk_o && !ser_data_o); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5

    AST_MAINS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !mains_ok_i |-> !ser_clk_o && !ser_data_o); // R7

    AST_MAINS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !mains_ok_i |=> !busy_o && !done_o); // R7

endmodule

bind bcd_shift_driver bcd_shift_driver_chk #(.NBITS(NBITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mains_ok_i (mains_ok_i),
    .ser_data_o (ser_data_o),
    .ser_clk_o  (ser_clk_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/bcd_shift_driver_tb.sv
`timescale 1ns/1ps
module bcd_shift_driver_tb_top;

    localparam int HD    = 4;
    localparam int NB    = 16;
    localparam int FRAME = 32 * HD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] digits_i = '0;
    logic        mains_ok_i = 1'b1;
    logic        map_we_i = 1'b0;
    logic [3:0]  map_addr_i = '0;
    logic [3:0]  map_data_i = '0;
    logic        ser_data_o, ser_clk_o, busy_o, done_o;

    always #5 clk = ~clk;

    bcd_shift_driver #(.HALF_DIV(HD)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .digits_i   (digits_i),
        .mains_ok_i (mains_ok_i),
        .map_we_i   (map_we_i),
        .map_addr_i (map_addr_i),
        .map_data_i (map_data_i),
        .ser_data_o (ser_data_o),
        .ser_clk_o  (ser_clk_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    int checks = 0;
    int fails  = 0;

    // register chain model and line monitor, sampled at the falling system edge
    logic [15:0] chain = '0;
    int rises = 0, gap_bad = 0, chg_hi = 0, done_cnt = 0;
    int cyc = 0, last_rise = 0;
    logic prev_clk = 1'b0, prev_dat = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (ser_clk_o && !prev_clk) begin
            chain = {chain[14:0], ser_data_o};
            if (rises > 0 && (cyc - last_rise) != 2 * HD) gap_bad = gap_bad + 1;
            last_rise = cyc;
            rises = rises + 1;
        end
        if (ser_clk_o && prev_clk && ser_data_o != prev_dat) chg_hi = chg_hi + 1;
        if (done_o) done_cnt = done_cnt + 1;
        prev_clk = ser_clk_o;
        prev_dat = ser_data_o;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic clear_mon();
        chain = '0; rises = 0; gap_bad = 0; chg_hi = 0; done_cnt = 0;
    endtask

    task automatic map_write(input int addr, input int val);
        map_we_i = 1'b1; map_addr_i = 4'(addr); map_data_i = 4'(val);
        step(1);
        map_we_i = 1'b0;
    endtask

    // pulse start for one cycle; on return busy_o shows the launch result
    task automatic launch(input logic [15:0] w);
        clear_mon();
        digits_i = w; start_i = 1'b1;
        step(1);
        start_i = 1'b0;
    endtask

    task automatic finish(input logic [15:0] exp, input string req, input int waited);
        int n = waited;
        while (!done_o && n < FRAME + 50) begin
            step(1);
            n++;
        end
        chk(n == FRAME + 1, "R2", "cycles to done", n, FRAME + 1);
        chk(busy_o == 1'b0, "R5", "busy at done", busy_o, 0);
        chk(ser_data_o == 1'b0 && ser_clk_o == 1'b0, "R5", "lines low at end",
            {ser_data_o, ser_clk_o}, 0);
        chk(rises == NB, "R2", "rising edge count", rises, NB);
        chk(gap_bad == 0, "R2", "edge spacing errors", gap_bad, 0);
        chk(chg_hi == 0, "R4", "data moved while clock high", chg_hi, 0);
        chk(chain == exp, req, "chain image", chain, exp);
        step(1);
        chk(done_o == 1'b0 && done_cnt == 1, "R5", "done pulse width", done_cnt, 1);
    endtask

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = v[15 - k];
        return r;
    endfunction

    // {digits, expected chain image} under the reset map (R3)
    localparam logic [31:0] VEC [6] = '{
        {16'h1234, 16'h1234},
        {16'h2359, 16'h2359},
        {16'h0000, 16'h0000},
        {16'h0001, 16'h0001},
        {16'h1200, 16'h1200},
        {16'h0959, 16'h0959}
    };

    initial begin : watchdog
        #1_500_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(!ser_data_o && !ser_clk_o && !busy_o && !done_o, "R1", "reset outputs",
            {ser_data_o, ser_clk_o, busy_o, done_o}, 0);

        // R3 vector walk under the reset map
        for (int v = 0; v < 6; v++) begin
            launch(VEC[v][31:16]);
            chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
            finish(VEC[v][15:0], "R3", 1);
            step(3);
        end

        // R6 start during busy is ignored
        launch(16'h1745);
        step(10);
        digits_i = 16'h0808; start_i = 1'b1;
        step(1);
        start_i = 1'b0;
        finish(16'h1745, "R6", 12);
        step(FRAME);
        chk(done_cnt == 1 && busy_o == 1'b0, "R6", "no second frame", done_cnt, 1);

        // R7 start while mains absent
        mains_ok_i = 1'b0;
        launch(16'h1111);
        step(5);
        chk(!busy_o && !ser_clk_o && !ser_data_o && rises == 0, "R7", "no launch without mains",
            {busy_o, ser_clk_o, ser_data_o}, 0);
        mains_ok_i = 1'b1;
        step(2);

        // R7 abort mid-frame: all ones so data is high when power drops
        launch(16'hFFFF);
        step(HD + 1);
        chk(ser_clk_o == 1'b1 && ser_data_o == 1'b1, "R7", "lines active before drop",
            {ser_clk_o, ser_data_o}, 3);
        mains_ok_i = 1'b0;
        #1;
        chk(!ser_clk_o && !ser_data_o, "R7", "lines low same cycle", {ser_clk_o, ser_data_o}, 0);
        step(1);
        chk(busy_o == 1'b0, "R7", "busy dropped", busy_o, 0);
        step(FRAME);
        chk(done_cnt == 0, "R7", "no done after abort", done_cnt, 0);
        mains_ok_i = 1'b1;
        step(2);

        // R8 reversed map: slot k sends bit k, chain holds bit-reversed word
        for (int k = 0; k < 16; k++) map_write(k, k);
        launch(16'h1234);
        finish(rev16(16'h1234), "R8", 1);
        step(2);

        // R8 table rewritten during a frame does not disturb it
        launch(16'h2047);
        for (int k = 0; k < 16; k++) map_write(k, 15 - k);
        finish(rev16(16'h2047), "R8", 17);
        step(2);
        launch(16'h2047);
        finish(16'h2047, "R8", 1);

        // R8 single entry swap of slots 0 and 15
        map_write(0, 0);
        map_write(15, 15);
        launch(16'h8000);
        finish(16'h0001, "R8", 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule